// File: doc/BRIEF.md
# Signed Saturating Add/Subtract Unit

This block performs 32-bit two's-complement arithmetic that never wraps. When the exact result falls outside the signed range, the output is pinned to the nearest representable extreme. A 2-bit operation code selects one of four operations: plain add, plain subtract, add of a doubled second operand, or subtract of a doubled second operand. In the two doubled forms the doubling is saturated on its own before the final add or subtract, which is then saturated again. The datapath is purely combinational. A single-cycle indication `sat_o` shows that some stage clamped during the current operation.

A sticky overflow flag keeps the history of these events. On every cycle with `valid_i` high, the flag takes the OR of its current value and `sat_o`. The flag falls back to zero only through the synchronous `clear_i` input or through reset. Reset is applied asynchronously and released on the clock through a short synchronizer.

Top module: `sat_alu`

## Requirements
- R1: When the exact result of the final stage is above 2^31-1, `result_o` is 0x7FFFFFFF.
- R2: When the exact result of the final stage is below -2^31, `result_o` is 0x80000000.
- R3: `sat_o` is 1 in the same cycle whenever any stage of the selected operation clamps its value.
- R4: Code 2'b00 gives SAT(A+B) and code 2'b01 gives SAT(A-B), where A is `a_i` and B is `b_i`.
- R5: Code 2'b10 gives SAT(A + SAT(2*B)).
- R6: Code 2'b11 gives SAT(A - SAT(2*B)).
- R7: When no stage clamps, `result_o` equals the exact result and `sat_o` is 0.
- R8: When only the doubling stage clamps, `sat_o` is 1 and `result_o` is the unclamped sum or difference of A and the clamped doubled value.
- R9: On a clock edge with `valid_i` high and `clear_i` low, `flag_o` becomes its previous value ORed with `sat_o`. With `valid_i` low, `flag_o` holds its value.
- R10: On a clock edge with `clear_i` high, `flag_o` becomes 0, even when `valid_i` and `sat_o` are both high.
- R11: `rst_ni` low forces `flag_o` to 0 at once. After `rst_ni` rises, the flag stays in reset for two more rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe; lets the flag absorb `sat_o` |
| clear_i | input | 1 | Synchronous clear of the sticky flag |
| op_i | input | 2 | Operation select: 00 add, 01 sub, 10 doubled add, 11 doubled sub |
| a_i | input | 32 | First operand, signed |
| b_i | input | 32 | Second operand, signed |
| result_o | output | 32 | Saturated result |
| sat_o | output | 1 | Saturation occurred in this operation |
| flag_o | output | 1 | Sticky overflow flag |

## Verification
The datapath holds no state, so a fault in the overflow detection or the clamp shows at `result_o` and `sat_o` in the same cycle as the operands that trigger it. A wrong flag register shows one edge later on `flag_o`. A flag that misses a set, clears itself or ignores the clear priority is seen on the first strobe after the event. A wrong reset-release depth shows as the flag staying stuck or releasing one edge early after `rst_ni` rises.

// File: rtl/sat_pkg.sv
package sat_pkg;
  parameter int unsigned SAT_W = 32;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DADD = 2'b10,
    OP_DSUB = 2'b11
  } sat_op_e;
endpackage

// File: rtl/sat_rst_sync.sv
module sat_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] pipe_q;
  logic [STAGES-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= pipe_d;
  end

  assign rst_no = pipe_q[STAGES-1];
endmodule

// File: rtl/sat_stage.sv
module sat_stage #(
  parameter int unsigned DATA_W = sat_pkg::SAT_W
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] y_o,
  output logic              ovf_o
);
  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  logic [DATA_W:0] x_ext, y_ext, wide;

  always_comb begin
    x_ext = {x_i[DATA_W-1], x_i};
    y_ext = {y_i[DATA_W-1], y_i};
    wide  = sub_i ? (x_ext - y_ext) : (x_ext + y_ext);
    ovf_o = wide[DATA_W] ^ wide[DATA_W-1];
    if (!ovf_o)              y_o = wide[DATA_W-1:0];
    else if (wide[DATA_W])   y_o = MIN_V;
    else                     y_o = MAX_V;
  end
endmodule

// File: rtl/sat_flag.sv
module sat_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic clear_i,
  input  logic sat_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_en = clear_i | valid_i;
    flag_d  = clear_i ? 1'b0 : (flag_q | sat_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  p_flag_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !clear_i) |=> $stable(flag_o));
  p_flag_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !flag_o);
  p_flag_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clear_i) |=> flag_o);
endmodule

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int unsigned DATA_W     = sat_pkg::SAT_W,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              clear_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              sat_o,
  output logic              flag_o
);
  import sat_pkg::*;

  localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};

  sat_op_e           op;
  logic              use_dbl, do_sub;
  logic [DATA_W-1:0] dbl_val, rhs;
  logic              dbl_ovf, fin_ovf;
  logic              rst_n;

  always_comb begin
    op      = sat_op_e'(op_i);
    use_dbl = (op == OP_DADD) || (op == OP_DSUB);
    do_sub  = (op == OP_SUB)  || (op == OP_DSUB);
    rhs     = use_dbl ? dbl_val : b_i;
  end

  sat_stage #(.DATA_W(DATA_W)) u_dbl (
    .x_i  (b_i),
    .y_i  (b_i),
    .sub_i(1'b0),
    .y_o  (dbl_val),
    .ovf_o(dbl_ovf)
  );

  sat_stage #(.DATA_W(DATA_W)) u_fin (
    .x_i  (a_i),
    .y_i  (rhs),
    .sub_i(do_sub),
    .y_o  (result_o),
    .ovf_o(fin_ovf)
  );

  assign sat_o = fin_ovf | (use_dbl & dbl_ovf);

  sat_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  sat_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .valid_i(valid_i),
    .clear_i(clear_i),
    .sat_i  (sat_o),
    .flag_o (flag_o)
  );

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (op_i == 2'b00 && !sat_o) |-> (result_o == a_i + b_i));
  p_clamp_edge_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!op_i[1] && sat_o) |-> (result_o == MAX_V || result_o == MIN_V));
  p_flag_set_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (valid_i && sat_o && !clear_i) |=> flag_o);
endmodule

// File: tb/sat_alu_tb.sv
module sat_alu_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        clear_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [31:0] result_o;
  logic        sat_o, flag_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sat_alu u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .clear_i(clear_i),
    .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .result_o(result_o), .sat_o(sat_o), .flag_o(flag_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b;
    #1;
  endtask

  task automatic op_check(input string req, input logic [1:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] er, input logic es);
    apply(op, a, b);
    chk({req, " result"}, result_o, er);
    chk({req, " sat"}, {31'd0, sat_o}, {31'd0, es});
  endtask

  task automatic t_reset;
    #1;
    chk("R11 flag in reset", {31'd0, flag_o}, 32'd0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    valid_i = 1'b1; op_i = 2'b00; a_i = 32'h7FFFFFFF; b_i = 32'd1;
    @(posedge clk); #1;
    chk("R11 first edge held", {31'd0, flag_o}, 32'd0);
    @(posedge clk); #1;
    chk("R11 second edge held", {31'd0, flag_o}, 32'd0);
    @(posedge clk); #1;
    chk("R11 released", {31'd0, flag_o}, 32'd1);
    @(negedge clk); valid_i = 1'b0; clear_i = 1'b1;
    @(negedge clk); clear_i = 1'b0;
  endtask

  task automatic t_plain;
    op_check("R4 add", 2'b00, 32'd5, 32'd7, 32'd12, 1'b0);
    op_check("R4 sub", 2'b01, 32'd3, 32'd10, 32'hFFFFFFF9, 1'b0);
    op_check("R7 add negative", 2'b00, 32'hFFFFFFFE, 32'hFFFFFFFD, 32'hFFFFFFFB, 1'b0);
    op_check("R1 add high clamp", 2'b00, 32'h7FFFFFFF, 32'd1, 32'h7FFFFFFF, 1'b1);
    op_check("R2 sub low clamp", 2'b01, 32'h80000000, 32'd1, 32'h80000000, 1'b1);
    op_check("R2 add low clamp", 2'b00, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1);
    op_check("R1 sub high clamp", 2'b01, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1);
    op_check("R7 add at max", 2'b00, 32'h7FFFFFFE, 32'd1, 32'h7FFFFFFF, 1'b0);
  endtask

  task automatic t_double;
    op_check("R5 dadd", 2'b10, 32'd100, 32'd3, 32'd106, 1'b0);
    op_check("R6 dsub", 2'b11, 32'd100, 32'hFFFFFFFD, 32'd106, 1'b0);
    op_check("R5 dadd B=0x40000000 A=0", 2'b10, 32'd0, 32'h40000000, 32'h7FFFFFFF, 1'b1);
    op_check("R8 dadd only doubling", 2'b10, 32'hFFFFFFFF, 32'h40000000, 32'h7FFFFFFE, 1'b1);
    op_check("R6 dsub B=0x40000000", 2'b11, 32'd0, 32'h40000000, 32'h80000001, 1'b1);
    op_check("R6 dsub B=0x80000000 A=0", 2'b11, 32'd0, 32'h80000000, 32'h7FFFFFFF, 1'b1);
    op_check("R8 dsub only doubling", 2'b11, 32'hFFFFFFFF, 32'h80000000, 32'h7FFFFFFF, 1'b1);
    op_check("R3 dadd both stages", 2'b10, 32'h7FFFFFFF, 32'h40000000, 32'h7FFFFFFF, 1'b1);
    op_check("R7 plain add ignores doubling", 2'b00, 32'd0, 32'h40000000, 32'h40000000, 1'b0);
  endtask

  task automatic t_flag;
    @(negedge clk); clear_i = 1'b1; @(negedge clk); clear_i = 1'b0;
    apply(2'b00, 32'h7FFFFFFF, 32'd1);
    @(posedge clk); #1;
    chk("R9 no valid holds 0", {31'd0, flag_o}, 32'd0);
    apply(2'b00, 32'd1, 32'd1); valid_i = 1'b1;
    @(posedge clk); #1;
    chk("R9 valid no sat", {31'd0, flag_o}, 32'd0);
    apply(2'b10, 32'hFFFFFFFF, 32'h40000000);
    @(posedge clk); #1;
    chk("R9 doubling-only sets flag", {31'd0, flag_o}, 32'd1);
    apply(2'b00, 32'd1, 32'd1);
    @(posedge clk); #1;
    chk("R9 sticky", {31'd0, flag_o}, 32'd1);
    apply(2'b00, 32'h7FFFFFFF, 32'd1); clear_i = 1'b1;
    @(posedge clk); #1;
    chk("R10 clear beats valid", {31'd0, flag_o}, 32'd0);
    @(negedge clk); clear_i = 1'b0;
    @(posedge clk); #1;
    chk("R9 set after clear", {31'd0, flag_o}, 32'd1);
    @(negedge clk); valid_i = 1'b0; rst_ni = 1'b0; #1;
    chk("R11 async reset", {31'd0, flag_o}, 32'd0);
    @(negedge clk); rst_ni = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_double();
    t_flag();
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule